// File: doc/BRIEF.md
# Radix Table Walker

This block turns an effective address into a real address by walking a radix tree of 8-byte entries held in memory. A request carries the effective address and a 64-bit root descriptor. The descriptor supplies three things: the base of the top-level directory, the index width used at that level, and the total address width covered by the tree. The walker fetches one entry per level through a simple read-request/read-data port. At each level it takes the next base and the next index width from the entry it has just read. The walk stops at a leaf entry, at an invalid entry, or at the first level whose geometry is not one of the supported shapes.

When the walk ends, the walker raises a one-cycle `done` pulse. On success it presents the real address, the page size as a bit count, the leaf entry and a fault code of zero. On failure it presents a non-zero fault code. It takes a new request only while it is idle. It keeps at most one memory read in flight and waits as long as needed for each response.

Top module: `rdx_walker`

## Requirements
- R1: After reset, and after any reset taken in the middle of a walk, `req_ready` is 1 while `done` and `rd_req` are 0, and no result pulse follows the reset.
- R2: Entry layout: bit 63 is valid, bit 62 is leaf, bits 59:8 are the next-level base and bits 4:0 are the next-level index width. At each level the entry address is (aligned base) + 8 × index, where the index is the effective address shifted right by (remaining width − index width) and masked to index-width bits.
- R3: In the root descriptor, bits 59:8 are the base and bits 4:0 are the index width. The total width is `{bits 62:61, bits 7:5} + 31`.
- R4: Before each read, the level geometry is checked. Level 0 requires a total width of 52 and an index width of 13. Levels 1 and 2 require an index width of 9. Level 3 accepts 9 or 5. A walk that needs a fifth level is rejected. Any violation ends the walk with fault code 2 (bad configuration) and issues no read for that level.
- R5: An entry with bit 63 clear ends the walk with fault code 1 (no entry).
- R6: A base with any of its low (index width + 3) bits set is used with those bits cleared, and no fault is raised. This applies to both the root base and the bases read from entries.
- R7: After each entry is read, the remaining width drops by that level's index width. On a leaf, `res_psize` equals the remaining width. `res_addr` takes leaf bits 56:12 above that width and the effective address below it. `res_leaf` holds the leaf entry, and the fault code is 0.
- R8: At most one read is outstanding. `rd_req` is a single-cycle pulse, and the walker does not advance until `rd_valid` arrives, whatever the response latency.
- R9: `done` is high for exactly one cycle per accepted request. A request presented while `req_ready` is 0 is ignored.
- R10: Effective-address bits at or above the total width do not affect the result, and leaf RPN bits below the page offset do not appear in `res_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_ea | input | 64 | Effective address to translate |
| req_root | input | 64 | Root descriptor (base, index width, total width) |
| rd_req | output | 1 | Memory read request, one cycle |
| rd_addr | output | 64 | Byte address of the entry to read |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 64 | Entry returned by memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 0 none, 1 no entry, 2 bad configuration |
| res_addr | output | 64 | Translated real address |
| res_psize | output | 7 | Page size in address bits |
| res_leaf | output | 64 | Leaf entry that ended the walk |

## Verification
The hardest cases to reach from the ports are the ones that need a deliberately malformed tree. These include a fourth-level entry that is not a leaf, an intermediate entry whose base is misaligned, and an intermediate entry that carries an illegal index width. The bench builds a single sparse memory image in which each top-level slot leads into its own small, hand-built subtree, so the effective address alone selects which corner case a walk reaches. Response latency is varied between walks. A reset is also applied while a read is still outstanding, to show that the walker returns to idle without a stray pulse.

// File: rtl/rdx_walk_pkg.sv
// Package: shared widths, entry field positions and small helpers for the
// radix table walker. Assumes 64-bit entries in the fixed layout below.
package rdx_walk_pkg;

    localparam int ENT_W     = 64;   // entry and address width
    localparam int SZ_W      = 7;    // holds a bit count up to 63
    localparam int ISZ_W     = 5;    // index width field
    localparam int ENT_LOG   = 3;    // log2 of entry size in bytes
    localparam int VALID_BIT = 63;
    localparam int LEAF_BIT  = 62;
    localparam int NB_HI     = 59;
    localparam int NB_LO     = 8;
    localparam int RPN_HI    = 56;
    localparam int RPN_LO    = 12;
    localparam int TW_BIAS   = 31;   // added to the encoded total width

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_NOENT  = 2'd1,
        FLT_BADCFG = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } state_e;

    // Build a mask with bits hi..lo set.
    function automatic logic [ENT_W-1:0] field_mask(input int hi, input int lo);
        logic [ENT_W-1:0] m;
        m = '0;
        for (int b = lo; b <= hi; b++) m[b] = 1'b1;
        return m;
    endfunction

    localparam logic [ENT_W-1:0] NB_MASK  = field_mask(NB_HI, NB_LO);
    localparam logic [ENT_W-1:0] RPN_MASK = field_mask(RPN_HI, RPN_LO);

    // Next-level base carried by a directory entry or root descriptor.
    function automatic logic [ENT_W-1:0] entry_base(input logic [ENT_W-1:0] e);
        return e & NB_MASK;
    endfunction

    // Total translated width encoded in a root descriptor.
    function automatic logic [SZ_W-1:0] root_width(input logic [ENT_W-1:0] r);
        return SZ_W'({r[62:61], r[7:5]}) + SZ_W'(TW_BIAS);
    endfunction

endpackage

// File: rtl/rdx_walk_geom.sv
// Geometry checker: decides whether the (level, remaining width, index width)
// triple is one of the supported radix shapes. Purely combinational; assumes
// the caller evaluates it before issuing the read for that level.
module rdx_walk_geom #(
    parameter int LVL_W     = 3,
    parameter int SZ_W      = 7,
    parameter int ISZ_W     = 5,
    parameter int LEVELS    = 4,
    parameter int ROOT_SIZE = 52,
    parameter int ROOT_ISZ  = 13,
    parameter int MID_ISZ   = 9,
    parameter int ALT_ISZ   = 5
) (
    input  logic [LVL_W-1:0] level,
    input  logic [SZ_W-1:0]  rem,
    input  logic [ISZ_W-1:0] isz,
    output logic             ok
);
    localparam int LAST = LEVELS - 1;

    // Classify the level and compare against its legal shapes.
    always_comb begin
        if (int'(level) == 0) begin
            ok = (rem == SZ_W'(ROOT_SIZE)) && (isz == ISZ_W'(ROOT_ISZ));
        end else if (int'(level) < LAST) begin
            ok = (isz == ISZ_W'(MID_ISZ));
        end else if (int'(level) == LAST) begin
            ok = (isz == ISZ_W'(MID_ISZ)) || (isz == ISZ_W'(ALT_ISZ));
        end else begin
            ok = 1'b0;
        end
    end

endmodule

// File: rtl/rdx_walk_index.sv
// Entry address generator: aligns the table base to its table size and adds
// the scaled index taken from the effective address. Assumes rem >= isz when
// the geometry check passed; the result is unused otherwise.
module rdx_walk_index #(
    parameter int ENT_W   = 64,
    parameter int SZ_W    = 7,
    parameter int ISZ_W   = 5,
    parameter int ENT_LOG = 3
) (
    input  logic [ENT_W-1:0] ea,
    input  logic [ENT_W-1:0] base,
    input  logic [ISZ_W-1:0] isz,
    input  logic [SZ_W-1:0]  rem,
    output logic [ENT_W-1:0] ent_addr
);
    logic [SZ_W-1:0]  align_bits;
    logic [SZ_W-1:0]  shamt;
    logic [ENT_W-1:0] align_mask;
    logic [ENT_W-1:0] idx_mask;
    logic [ENT_W-1:0] idx;

    // Clear misaligned base bits and select the index field of the address.
    always_comb begin
        align_bits = SZ_W'(isz) + SZ_W'(ENT_LOG);
        align_mask = ~((ENT_W'(1) << align_bits) - ENT_W'(1));
        shamt      = rem - SZ_W'(isz);
        idx_mask   = (ENT_W'(1) << isz) - ENT_W'(1);
        idx        = (ea >> shamt) & idx_mask;
        ent_addr   = (base & align_mask) + (idx << ENT_LOG);
    end

endmodule

// File: rtl/rdx_walk_leaf.sv
// Leaf composer: merges the page number of a leaf entry with the page offset
// of the effective address. Assumes page_bits < ENT_W.
module rdx_walk_leaf #(
    parameter int ENT_W = 64,
    parameter int SZ_W  = 7
) (
    input  logic [ENT_W-1:0] leaf,
    input  logic [ENT_W-1:0] ea,
    input  logic [SZ_W-1:0]  page_bits,
    input  logic [ENT_W-1:0] rpn_mask,
    output logic [ENT_W-1:0] raddr
);
    logic [ENT_W-1:0] off_mask;
    logic [ENT_W-1:0] rpn;

    // Take page frame bits above the offset and address bits below it.
    always_comb begin
        off_mask = (ENT_W'(1) << page_bits) - ENT_W'(1);
        rpn      = leaf & rpn_mask;
        raddr    = (rpn & ~off_mask) | (ea & off_mask);
    end

endmodule

// File: rtl/rdx_walker.sv
// Radix table walker top. Accepts one walk at a time, reads one entry per
// level through a single-outstanding read port, and reports the translated
// address or a fault with a one-cycle done pulse. Assumes memory answers each
// read exactly once with rd_valid, at any latency of one cycle or more.
module rdx_walker #(
    parameter int LEVELS    = 4,
    parameter int ROOT_SIZE = 52,
    parameter int ROOT_ISZ  = 13,
    parameter int MID_ISZ   = 9,
    parameter int ALT_ISZ   = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] req_ea,
    input  logic [63:0] req_root,
    output logic        rd_req,
    output logic [63:0] rd_addr,
    input  logic        rd_valid,
    input  logic [63:0] rd_data,
    output logic        done,
    output logic [1:0]  fault,
    output logic [63:0] res_addr,
    output logic [6:0]  res_psize,
    output logic [63:0] res_leaf
);
    import rdx_walk_pkg::*;

    localparam int LVL_W    = $clog2(LEVELS + 1);
    localparam int MIN_PAGE = ROOT_SIZE - ROOT_ISZ - (LEVELS - 1) * MID_ISZ;

    state_e            st_q;
    fault_e            fault_q;
    logic [ENT_W-1:0]  ea_q;
    logic [ENT_W-1:0]  base_q;
    logic [ISZ_W-1:0]  isz_q;
    logic [SZ_W-1:0]   rem_q;
    logic [LVL_W-1:0]  lvl_q;
    logic              geom_ok;
    logic [ENT_W-1:0]  ent_addr;
    logic [ENT_W-1:0]  leaf_addr;
    logic [SZ_W-1:0]   rem_next;

    // Remaining width once the current level's index bits are consumed.
    assign rem_next  = rem_q - SZ_W'(isz_q);
    // Handshake and read-port outputs.
    assign req_ready = (st_q == ST_IDLE);
    assign rd_req    = (st_q == ST_ISSUE) && geom_ok;
    assign rd_addr   = ent_addr;
    assign fault     = fault_q;

    rdx_walk_geom #(
        .LVL_W(LVL_W), .SZ_W(SZ_W), .ISZ_W(ISZ_W), .LEVELS(LEVELS),
        .ROOT_SIZE(ROOT_SIZE), .ROOT_ISZ(ROOT_ISZ),
        .MID_ISZ(MID_ISZ), .ALT_ISZ(ALT_ISZ)
    ) geom_i (
        .level (lvl_q),
        .rem   (rem_q),
        .isz   (isz_q),
        .ok    (geom_ok)
    );

    rdx_walk_index #(
        .ENT_W(ENT_W), .SZ_W(SZ_W), .ISZ_W(ISZ_W), .ENT_LOG(ENT_LOG)
    ) index_i (
        .ea       (ea_q),
        .base     (base_q),
        .isz      (isz_q),
        .rem      (rem_q),
        .ent_addr (ent_addr)
    );

    rdx_walk_leaf #(
        .ENT_W(ENT_W), .SZ_W(SZ_W)
    ) leaf_i (
        .leaf      (rd_data),
        .ea        (ea_q),
        .page_bits (rem_next),
        .rpn_mask  (RPN_MASK),
        .raddr     (leaf_addr)
    );

    // Walk sequencer: latch request, check geometry, read, descend or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            fault_q   <= FLT_NONE;
            ea_q      <= '0;
            base_q    <= '0;
            isz_q     <= '0;
            rem_q     <= '0;
            lvl_q     <= '0;
            done      <= 1'b0;
            res_addr  <= '0;
            res_psize <= '0;
            res_leaf  <= '0;
        end else begin
            done <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        ea_q   <= req_ea;
                        base_q <= entry_base(req_root);
                        isz_q  <= req_root[ISZ_W-1:0];
                        rem_q  <= root_width(req_root);
                        lvl_q  <= '0;
                        st_q   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (!geom_ok) begin
                        done    <= 1'b1;
                        fault_q <= FLT_BADCFG;
                        st_q    <= ST_IDLE;
                    end else begin
                        st_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rd_valid) begin
                        if (!rd_data[VALID_BIT]) begin
                            done    <= 1'b1;
                            fault_q <= FLT_NOENT;
                            st_q    <= ST_IDLE;
                        end else if (rd_data[LEAF_BIT]) begin
                            done      <= 1'b1;
                            fault_q   <= FLT_NONE;
                            res_addr  <= leaf_addr;
                            res_psize <= rem_next;
                            res_leaf  <= rd_data;
                            st_q      <= ST_IDLE;
                        end else begin
                            base_q <= entry_base(rd_data);
                            isz_q  <= rd_data[ISZ_W-1:0];
                            rem_q  <= rem_next;
                            lvl_q  <= lvl_q + LVL_W'(1);
                            st_q   <= ST_ISSUE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R8: a read request never repeats in the following cycle.
    p_single_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req)
        else $error("read request held for two cycles");

    // R8: a response only arrives while a read is outstanding.
    p_resp_in_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (st_q == ST_WAIT))
        else $error("read response with no read outstanding");

    // R9: completion is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done held for two cycles");

    // R9: a request while busy does not disturb the latched address.
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> $stable(ea_q))
        else $error("busy request changed the walk address");

    // R4: the level counter never passes the depth limit.
    p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |-> (int'(lvl_q) <= LEVELS))
        else $error("walk deeper than the level limit");

    // R7: a successful walk reports a page size from the legal range.
    p_psize_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_q == FLT_NONE) |->
            (int'(res_psize) >= MIN_PAGE && int'(res_psize) <= ROOT_SIZE - ROOT_ISZ))
        else $error("page size outside the legal range");

endmodule

// File: tb/rdx_walker_tb_top.sv
// Bench for the radix table walker: a vector table walked by one loop over a
// shared sparse memory image, then directed tests for reset, busy requests
// and long read latency.
module rdx_walker_tb_top;

    localparam int CLK_NS = 10;
    localparam int NMEM   = 20;
    localparam int NVEC   = 13;
    localparam logic [63:0] ROOT_A = 64'h4000_0000_0010_00AD;
    localparam logic [63:0] LEAF_A = 64'hC000_0000_7654_3103;

    // Sparse memory image: each top-level slot leads to its own subtree.
    localparam logic [63:0] MEM_A [NMEM] = '{
        64'h10_0000, 64'h20_0000, 64'h30_0000, 64'h40_0000,
        64'h10_0008, 64'h50_0010, 64'h60_0018,
        64'h10_0010, 64'h70_0008,
        64'h10_0018, 64'h80_0000, 64'h90_0000, 64'hA0_0020,
        64'h10_0020,
        64'h10_0028, 64'hC0_0000, 64'hD0_0000, 64'hE0_0000,
        64'h10_0030, 64'h10_0038
    };
    localparam logic [63:0] MEM_D [NMEM] = '{
        64'h8000_0000_0020_0009, 64'h8000_0000_0030_0009,
        64'h8000_0000_0040_0009, LEAF_A,
        64'h8000_0000_0050_0009, 64'h8000_0000_0060_0009,
        64'hC000_0000_ABC5_5000,
        64'h8000_0000_0070_0009, 64'hC000_0012_3456_7000,
        64'h8000_0000_0080_0009, 64'h8000_0000_0090_0009,
        64'h8000_0000_00A0_0005, 64'hC000_0000_5555_0000,
        64'h8000_0000_00B0_0008,
        64'h8000_0000_00C0_0009, 64'h8000_0000_00D0_0009,
        64'h8000_0000_00E0_0009, 64'h8000_0000_00F0_0009,
        64'h8000_0000_0020_0109, 64'hC000_0080_0000_0000
    };

    // Vectors: effective address, root, expected address/size/leaf/fault/reads.
    localparam logic [63:0] V_EA [NVEC] = '{
        64'h0000_0000_0000_0ABC, // R7 four-level 4 KiB page
        64'h0000_0080_8061_2345, // R10 leaf low bits masked, 2 MiB page
        64'h0000_0100_4ABC_DEF0, // R2 leaf at level 1
        64'h0000_0000_00A0_0000, // R5 empty slot at level 2
        64'h0000_0180_0004_BEEF, // R4 level 3 with 5-bit index
        64'h0000_0200_0000_0000, // R4 illegal index width at level 1
        64'h0000_0000_0000_0000, // R4 illegal root index width
        64'h0000_0000_0000_0000, // R3 root width decodes to 48
        64'h0000_0280_0000_0000, // R4 fifth level needed
        64'h0000_0300_0000_0123, // R6 misaligned directory base
        64'h0000_0000_0000_0055, // R6 misaligned root base
        64'h0000_0392_3456_789A, // R7 leaf at level 0
        64'hF000_0000_0000_0ABC  // R10 bits above total width ignored
    };
    localparam logic [63:0] V_ROOT [NVEC] = '{
        ROOT_A, ROOT_A, ROOT_A, ROOT_A, ROOT_A, ROOT_A,
        64'h4000_0000_0010_00AC, 64'h4000_0000_0010_002D,
        ROOT_A, ROOT_A, 64'h4000_0000_0010_80AD, ROOT_A, ROOT_A
    };
    localparam logic [63:0] V_ADDR [NVEC] = '{
        64'h7654_3ABC, 64'hABC1_2345, 64'h12_0ABC_DEF0, 64'h0,
        64'h5555_BEEF, 64'h0, 64'h0, 64'h0, 64'h0,
        64'h7654_3123, 64'h7654_3055, 64'h92_3456_789A, 64'h7654_3ABC
    };
    localparam logic [63:0] V_LEAF [NVEC] = '{
        LEAF_A, 64'hC000_0000_ABC5_5000, 64'hC000_0012_3456_7000, 64'h0,
        64'hC000_0000_5555_0000, 64'h0, 64'h0, 64'h0, 64'h0,
        LEAF_A, LEAF_A, 64'hC000_0080_0000_0000, LEAF_A
    };
    localparam int V_PS  [NVEC] = '{12, 21, 30, 0, 16, 0, 0, 0, 0, 12, 12, 39, 12};
    localparam int V_FLT [NVEC] = '{0, 0, 0, 1, 0, 2, 2, 2, 2, 0, 0, 0, 0};
    localparam int V_NRD [NVEC] = '{4, 3, 2, 3, 4, 1, 0, 0, 4, 4, 4, 1, 4};

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_ea;
    logic [63:0] req_root;
    logic        rd_req;
    logic [63:0] rd_addr;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        done;
    logic [1:0]  fault;
    logic [63:0] res_addr;
    logic [6:0]  res_psize;
    logic [63:0] res_leaf;

    int          total;
    int          bad;
    int          lat;
    int          reads_seen;
    int          extra_req;
    logic [63:0] resp_addr;

    rdx_walker dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_ea    (req_ea),
        .req_root  (req_root),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .done      (done),
        .fault     (fault),
        .res_addr  (res_addr),
        .res_psize (res_psize),
        .res_leaf  (res_leaf)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_NS / 2) clk = ~clk;
    end

    function automatic logic [63:0] mem_lookup(input logic [63:0] a);
        for (int k = 0; k < NMEM; k++) begin
            if (MEM_A[k] == a) return MEM_D[k];
        end
        return 64'h0;
    endfunction

    function automatic string vtag(input int i);
        case (i)
            0, 11:    return "R7";
            1, 12:    return "R10";
            2:        return "R2";
            3:        return "R5";
            7:        return "R3";
            9, 10:    return "R6";
            default:  return "R4";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory responder: one read at a time, answered after lat cycles.
    initial begin
        rd_valid  = 1'b0;
        rd_data   = '0;
        resp_addr = '0;
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (rd_req && rst_n) begin
                resp_addr = rd_addr;
                reads_seen++;
                for (int w = 0; w < lat; w++) begin
                    @(negedge clk);
                    if (rd_req) extra_req++;
                end
                if (rst_n) begin
                    rd_valid = 1'b1;
                    rd_data  = mem_lookup(resp_addr);
                end
            end
        end
    end

    // Issue one walk and wait for its done pulse.
    task automatic walk(input logic [63:0] ea, input logic [63:0] root, input int lat_in,
                        output bit timed_out);
        int cnt;
        lat        = lat_in;
        reads_seen = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_ea    = ea;
        req_root  = root;
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        while (!done && cnt < 400) begin
            @(negedge clk);
            cnt++;
        end
        timed_out = !done;
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit to;
        total     = 0;
        bad       = 0;
        lat       = 1;
        extra_req = 0;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_ea    = '0;
        req_root  = '0;
        repeat (4) @(negedge clk);
        // R1: reset state.
        chk("R1", 64'(req_ready), 64'd1);
        chk("R1", 64'(done), 64'd0);
        chk("R1", 64'(rd_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walked by one loop.
        for (int i = 0; i < NVEC; i++) begin
            walk(V_EA[i], V_ROOT[i], 1 + (i % 3), to);
            chk("R9", 64'(to), 64'd0);
            chk(vtag(i), 64'(fault), 64'(V_FLT[i]));
            chk("R8", 64'(reads_seen), 64'(V_NRD[i]));
            if (V_FLT[i] == 0) begin
                chk(vtag(i), res_addr, V_ADDR[i]);
                chk(vtag(i), 64'(res_psize), 64'(V_PS[i]));
                chk(vtag(i), res_leaf, V_LEAF[i]);
            end
        end

        // R8: long response latency still completes the walk correctly.
        walk(V_EA[1], ROOT_A, 7, to);
        chk("R8", 64'(to), 64'd0);
        chk("R8", res_addr, V_ADDR[1]);
        chk("R8", 64'(reads_seen), 64'd3);

        // R9: a request held while busy is ignored; done lasts one cycle.
        lat        = 2;
        reads_seen = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_ea    = V_EA[0];
        req_root  = ROOT_A;
        @(negedge clk);
        req_ea    = V_EA[2];
        chk("R9", 64'(req_ready), 64'd0);
        for (int c = 0; c < 400 && !done; c++) @(negedge clk);
        req_valid = 1'b0;
        chk("R9", res_addr, V_ADDR[0]);
        chk("R9", 64'(reads_seen), 64'd4);
        @(negedge clk);
        chk("R9", 64'(done), 64'd0);
        repeat (3) @(negedge clk);
        chk("R9", 64'(req_ready), 64'd1);
        chk("R9", 64'(reads_seen), 64'd4);

        // R1: reset in the middle of a walk returns to idle with no pulse.
        lat = 3;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_ea    = V_EA[0];
        req_root  = ROOT_A;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        begin
            int pulses;
            pulses = 0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (done) pulses++;
            end
            chk("R1", 64'(pulses), 64'd0);
        end
        chk("R1", 64'(req_ready), 64'd1);
        walk(V_EA[0], ROOT_A, 1, to);
        chk("R1", res_addr, V_ADDR[0]);

        // R8: no second request while a read was outstanding.
        chk("R8", 64'(extra_req), 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule